// File: doc/BRIEF.md
# Tree Magnitude Comparator

This block compares two unsigned operands and reports how they relate. Exactly one of three outputs is high: greater, equal or less. It is purely combinational, so the result follows the operands within the same cycle. It has no clock or reset, and it can sit in any datapath that needs a wide unsigned ordering decision.

The comparison uses identical four-bit comparator slices. Each slice decides on its own data bits first. It falls back to its cascade flags only when those bits match. The operand is cut into five-bit groups. In each group the top four bits go to the slice data pins, and the lowest bit enters through the slice's cascade flags. A final slice then combines the greater/less pairs of all groups, with the most significant group taking precedence. The path is two slices deep instead of a chain of six.

Top module: `tree_mag_cmp`

## Requirements
- R1: `gt_o` is high, and only `gt_o`, whenever `a_i` is greater than `b_i` as unsigned numbers.
- R2: `lt_o` is high, and only `lt_o`, whenever `a_i` is less than `b_i` as unsigned numbers.
- R3: `eq_o` is high, and only `eq_o`, whenever `a_i` equals `b_i`, including all-zero and all-one operands.
- R4: For every operand pair exactly one of `gt_o`, `eq_o`, `lt_o` is high.
- R5: When the operands differ only in bit 0, that bit alone decides the result.
- R6: When the operands differ in bit 24, that bit decides the result whatever the lower 24 bits hold.
- R7: The most significant differing five-bit group (bits 24..20, 19..15, 14..10, 9..5, 4..0) decides the result, even if every lower group points the other way.
- R8: Inside a group, bits 4..1 of the group outweigh bit 0 of the group. Bit 0 decides only when bits 4..1 match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i  | input  | 25 | First unsigned operand |
| b_i  | input  | 25 | Second unsigned operand |
| gt_o | output | 1  | High when `a_i` > `b_i` |
| eq_o | output | 1  | High when `a_i` == `b_i` |
| lt_o | output | 1  | High when `a_i` < `b_i` |

## Verification
The embedded assertions are immediate checks on settled combinational values. They assume both operands are fully driven two-state values, because an unknown bit would make the reference relation meaningless. The stimulus always drives complete 25-bit values, both random and hand-picked. It changes them only just after a clock edge, and the result is sampled half a period later, when the network has settled. The hand-picked cases aim at group boundaries and at the in-group rule that bit 0 is consulted only as a tie-breaker.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  typedef struct packed {
    logic gt;
    logic eq;
    logic lt;
  } cmp_flags_t;

  localparam cmp_flags_t FLAGS_GT = '{gt: 1'b1, eq: 1'b0, lt: 1'b0};
  localparam cmp_flags_t FLAGS_LT = '{gt: 1'b0, eq: 1'b0, lt: 1'b1};
endpackage

// File: rtl/cmp_slice.sv
module cmp_slice
  import cmp_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  cmp_flags_t   cin,
  output cmp_flags_t   res
);
  always_comb begin
    if (a > b)      res = FLAGS_GT;
    else if (a < b) res = FLAGS_LT;
    else            res = cin;
  end

  always_comb begin
    // R8
    data_wins_chk: assert ((a == b) || (res.eq == 1'b0 && (res.gt == (a > b))));
    // R8
    cascade_pass_chk: assert ((a != b) || (res == cin));
  end
endmodule

// File: rtl/cmp_group.sv
module cmp_group
  import cmp_pkg::*;
#(
  parameter int GW = 5
) (
  input  logic [GW-1:0] a,
  input  logic [GW-1:0] b,
  output cmp_flags_t    res
);
  localparam int SW = GW - 1;

  cmp_flags_t low_bit;

  always_comb begin
    low_bit.gt = a[0] & ~b[0];
    low_bit.eq = 1'b0;
    low_bit.lt = ~a[0] & b[0];
  end

  cmp_slice #(.W(SW)) u_slice (
    .a   (a[GW-1:1]),
    .b   (b[GW-1:1]),
    .cin (low_bit),
    .res (res)
  );

  always_comb begin
    // R8
    group_dir_chk: assert ((res.gt == (a > b)) && (res.lt == (a < b)));
  end
endmodule

// File: rtl/cmp_merge.sv
module cmp_merge
  import cmp_pkg::*;
#(
  parameter int N = 5
) (
  input  cmp_flags_t [N-1:0] part,
  output cmp_flags_t         res
);
  localparam int SW = N - 1;

  logic [SW-1:0] hi_a;
  logic [SW-1:0] hi_b;
  cmp_flags_t    base;

  for (genvar i = 0; i < SW; i++) begin : g_pair
    assign hi_a[i] = part[i+1].gt;
    assign hi_b[i] = part[i+1].lt;
  end

  always_comb begin
    base.gt = part[0].gt;
    base.lt = part[0].lt;
    base.eq = ~part[0].gt & ~part[0].lt;
  end

  cmp_slice #(.W(SW)) u_top (
    .a   (hi_a),
    .b   (hi_b),
    .cin (base),
    .res (res)
  );
endmodule

// File: rtl/tree_mag_cmp.sv
module tree_mag_cmp
  import cmp_pkg::*;
#(
  parameter int DATA_W = 25,
  parameter int SLICE_W = 4
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              gt_o,
  output logic              eq_o,
  output logic              lt_o
);
  localparam int GROUP_W = SLICE_W + 1;
  localparam int NUM_GRP = DATA_W / GROUP_W;

  cmp_flags_t [NUM_GRP-1:0] part;
  cmp_flags_t               final_res;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    cmp_group #(.GW(GROUP_W)) u_grp (
      .a   (a_i[g*GROUP_W +: GROUP_W]),
      .b   (b_i[g*GROUP_W +: GROUP_W]),
      .res (part[g])
    );
  end

  cmp_merge #(.N(NUM_GRP)) u_merge (
    .part (part),
    .res  (final_res)
  );

  assign gt_o = final_res.gt;
  assign eq_o = final_res.eq;
  assign lt_o = final_res.lt;

  always_comb begin
    // R4
    one_hot_res_chk: assert ($onehot({gt_o, eq_o, lt_o}));
    // R1
    gt_sound_chk: assert (gt_o == (a_i > b_i));
    // R2
    lt_sound_chk: assert (lt_o == (a_i < b_i));
    // R3
    eq_sound_chk: assert (eq_o == (a_i == b_i));
  end
endmodule

// File: tb/tree_mag_cmp_tb.sv
module tree_mag_cmp_tb;
  localparam int W = 25;

  typedef struct {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [2:0]   exp;
    string        tag;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a_i = '0;
  logic [W-1:0] b_i = '0;
  logic gt_o, eq_o, lt_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  item_t sb[$];

  always #10 clk = ~clk;

  tree_mag_cmp u_dut (
    .a_i (a_i), .b_i (b_i),
    .gt_o(gt_o), .eq_o(eq_o), .lt_o(lt_o)
  );

  function automatic logic [2:0] model(input logic [W-1:0] a, input logic [W-1:0] b);
    return {a > b, a == b, a < b};
  endfunction

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    item_t it;
    @(posedge clk);
    #1;
    a_i = a;
    b_i = b;
    it.a = a; it.b = b; it.exp = model(a, b); it.tag = tag;
    sb.push_back(it);
  endtask

  function automatic string rel_tag(input logic [W-1:0] a, input logic [W-1:0] b);
    if (a > b) return "R1";
    if (a < b) return "R2";
    return "R3";
  endfunction

  always @(negedge clk) begin
    if (!rst && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if ({gt_o, eq_o, lt_o} !== it.exp) begin
        errors++;
        $display("FAIL %s a=%h b=%h actual gt/eq/lt=%b expected=%b",
                 it.tag, it.a, it.b, {gt_o, eq_o, lt_o}, it.exp);
      end
      checks++;
      if ($countones({gt_o, eq_o, lt_o}) != 1) begin
        errors++;
        $display("FAIL R4 a=%h b=%h actual ones=%0d expected=1",
                 it.a, it.b, $countones({gt_o, eq_o, lt_o}));
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // reset state: zero operands compare equal (R3)
    drive('0, '0, "R3");
    drive({W{1'b1}}, {W{1'b1}}, "R3");
    drive(25'h0AB_CDEF, 25'h0AB_CDEF, "R3");
    // R5: only bit 0 differs
    drive(25'h000_0001, 25'h000_0000, "R5");
    drive(25'h155_5554, 25'h155_5555, "R5");
    drive(25'h1FF_FFFF, 25'h1FF_FFFE, "R5");
    // R6: bit 24 decides against opposite lower bits
    drive(25'h100_0000, 25'h0FF_FFFF, "R6");
    drive(25'h0FF_FFFF, 25'h100_0000, "R6");
    drive(25'h100_0000, 25'h000_0000, "R6");
    // R7: higher group wins over all lower groups
    drive({5'd0, 5'd3, 15'h0}, {5'd0, 5'd2, 15'h7FFF}, "R7");
    drive({10'd0, 5'd1, 10'h0}, {10'd0, 5'd2, 10'h000}, "R7");
    drive({20'd0, 5'd9}, {20'd0, 5'd8}, "R7");
    drive({15'd0, 5'd0, 5'd31}, {15'd0, 5'd1, 5'd0}, "R7");
    // R8: bits 4..1 of a group outweigh its bit 0
    drive({20'd0, 5'b10000}, {20'd0, 5'b01111}, "R8");
    drive({15'd0, 5'b00110, 5'd0}, {15'd0, 5'b00111, 5'd0}, "R8");
    drive({15'd0, 5'b01001, 5'd0}, {15'd0, 5'b01000, 5'd0}, "R8");
    drive({5'b00010, 20'd0}, {5'b00001, 20'd0}, "R8");
    // random pairs, with occasional forced equality or single-bit flips
    for (int i = 0; i < 3000; i++) begin
      logic [W-1:0] ra, rb;
      ra = W'($urandom);
      rb = W'($urandom);
      if (i % 7 == 0) rb = ra;
      else if (i % 7 == 1) rb = ra ^ (W'(1) << ($urandom % W));
      drive(ra, rb, rel_tag(ra, rb));
    end
    repeat (3) @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule